// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block sits beside an SRAM port and watches every access that chip enable qualifies. When six reads arrive at a fixed series of addresses, it raises a one-cycle command. The first five addresses are a shared prefix. The sixth address chooses between a store command and a recall command. The engines that carry out these commands are outside this block.

After a command fires, the block holds a memory-disable output high for a busy time. That time is set by a parameter, in clock cycles, and it is separate for store and for recall. The sequence reads themselves are not blocked. The detector only observes them, so they still return normal SRAM data.

Any write breaks a partly matched sequence. A read at an unexpected address also breaks it. Cycles with no access leave the progress unchanged.

Top module: `nvcmd_unlock`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, store_cmd, recall_cmd and mem_disable are all low, and the matcher holds no progress.
- R2: Six qualified reads arrive in exact order at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0. store_cmd is then high for exactly the one cycle that follows the clock edge sampling the sixth read.
- R3: The same five-address prefix followed by a read at 0x0C63 raises recall_cmd for exactly one cycle, with the same timing as R2.
- R4: A qualified write (acc_read low) returns the matcher to the start, whatever its progress. A sixth access at a selecting address that is a write fires no command.
- R5: A qualified read at an address other than the expected one returns the matcher to the start. The exception is a read at 0x0E38, which leaves the matcher having matched the first step.
- R6: Cycles with acc_valid low neither advance nor reset the matcher.
- R7: mem_disable rises in the same cycle as store_cmd and stays high for exactly STORE_CYCLES cycles.
- R8: mem_disable rises in the same cycle as recall_cmd and stays high for exactly RECALL_CYCLES cycles.
- R9: Accesses made while mem_disable is high are ignored. They fire no command, and the matcher is at the start when mem_disable falls.
- R10: store_cmd and recall_cmd are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, already qualified by chip enable |
| acc_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | ADDR_W | Access address |
| store_cmd | output | 1 | One-cycle store command |
| recall_cmd | output | 1 | One-cycle recall command |
| mem_disable | output | 1 | High while the triggered operation is busy |

## Verification
Directed runs cover several cases:
- Clean store and recall sequences, which show that the sixth address selects the command.
- Breaks at different steps by a write and by a stray read, which show that a broken sequence cannot fire.
- A stray 0x0E38 in mid-sequence, which separates "restart at step one" from "restart at zero".
- Idle gaps between steps, which show that only qualified accesses count.
- Full sequences sent during the busy window, which show that accesses are ignored while disabled and leave no progress behind.

Biased random traffic mixes correct next addresses, stray reads, writes and idle cycles. Every output is compared each cycle with a bench model. This exposes errors in pulse timing, in busy length, and in how store and recall interact.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = 3;

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } nv_cmd_e;

  localparam logic [31:0] STORE_KEY  = 32'h0000_0FC0;
  localparam logic [31:0] RECALL_KEY = 32'h0000_0C63;

  // Expected address of prefix step idx (0..PREFIX_LEN-1).
  function automatic logic [31:0] prefix_addr(input step_t idx);
    case (idx)
      3'd0:    return 32'h0000_0E38;
      3'd1:    return 32'h0000_31C7;
      3'd2:    return 32'h0000_03E0;
      3'd3:    return 32'h0000_3C1F;
      3'd4:    return 32'h0000_303F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Progress after a read that did not fire a command.
  function automatic step_t after_read(input step_t cur, input logic expected_hit,
                                       input logic first_hit);
    if (expected_hit) return step_t'(cur + 1'b1);
    if (first_hit)    return step_t'(1);
    return '0;
  endfunction

  // Busy length for a command.
  function automatic int unsigned busy_len(input nv_cmd_e c, input int unsigned st,
                                           input int unsigned rc);
    case (c)
      CMD_STORE:  return st;
      CMD_RECALL: return rc;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/nvcmd_matcher.sv
module nvcmd_matcher
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  output nv_cmd_e           hit,
  output step_t             step_o
);
  step_t       step_q, step_d;
  logic        take;
  logic [31:0] addr_w;
  logic        expected_hit, first_hit, store_hit, recall_hit, at_select;

  always_comb begin
    take         = acc_valid && !busy;
    addr_w       = 32'(acc_addr);
    at_select    = (step_q == step_t'(PREFIX_LEN));
    expected_hit = !at_select && (addr_w == prefix_addr(step_q));
    first_hit    = (addr_w == prefix_addr('0));
    store_hit    = at_select && (addr_w == STORE_KEY);
    recall_hit   = at_select && (addr_w == RECALL_KEY);
  end

  always_comb begin
    step_d = step_q;
    hit    = CMD_NONE;
    if (take) begin
      if (!acc_read) begin
        step_d = '0;
      end else if (store_hit) begin
        hit    = CMD_STORE;
        step_d = '0;
      end else if (recall_hit) begin
        hit    = CMD_RECALL;
        step_d = '0;
      end else begin
        step_d = after_read(step_q, expected_hit, first_hit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step_o = step_q;

  p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= step_t'(PREFIX_LEN));
  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_read && !busy) |=> (step_q == '0));
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !busy) |=> $stable(step_q));
  p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step_q == '0));
endmodule

// File: rtl/nvcmd_busy_timer.sv
module nvcmd_busy_timer
  import nvcmd_pkg::*;
#(
  parameter int unsigned STORE_CYCLES  = 64,
  parameter int unsigned RECALL_CYCLES = 40
) (
  input  logic    clk,
  input  logic    rst_n,
  input  nv_cmd_e load,
  output logic    busy
);
  localparam int unsigned MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             loading;

  assign loading = (load != CMD_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (loading)           cnt_q <= CNT_W'(busy_len(load, STORE_CYCLES, RECALL_CYCLES));
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !loading) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_load_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load == CMD_STORE) |=> (cnt_q == CNT_W'(STORE_CYCLES)));
  p_load_recall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load == CMD_RECALL) |=> (cnt_q == CNT_W'(RECALL_CYCLES)));
endmodule

// File: rtl/nvcmd_unlock.sv
module nvcmd_unlock
  import nvcmd_pkg::*;
#(
  parameter int          ADDR_W        = 15,
  parameter int unsigned STORE_CYCLES  = 64,
  parameter int unsigned RECALL_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              mem_disable
);
  nv_cmd_e hit_ev;
  step_t   match_step;
  logic    busy_w;

  nvcmd_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_read  (acc_read),
    .acc_addr  (acc_addr),
    .busy      (busy_w),
    .hit       (hit_ev),
    .step_o    (match_step)
  );

  nvcmd_busy_timer #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hit_ev),
    .busy  (busy_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
    end else begin
      store_cmd  <= (hit_ev == CMD_STORE);
      recall_cmd <= (hit_ev == CMD_RECALL);
    end
  end

  assign mem_disable = busy_w;

  p_cmd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_cmd && recall_cmd));
  p_store_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |=> !store_cmd);
  p_recall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |=> !recall_cmd);
  p_store_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |-> mem_disable);
  p_recall_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |-> mem_disable);
  p_no_cmd_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd || recall_cmd) |-> !$past(mem_disable));
  p_prefix_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev != CMD_NONE) |-> (match_step == step_t'(PREFIX_LEN)));
endmodule

// File: tb/nvcmd_unlock_test.sv
`timescale 1ns/100ps
module nvcmd_unlock_test;
  localparam int ADDR_W = 15;
  localparam int SC     = 12;
  localparam int RC     = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic              acc_read = 1'b1;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              store_cmd, recall_cmd, mem_disable;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int mstep = 0;
  int mbusy = 0;

  always #2.5 clk = ~clk;

  nvcmd_unlock #(.ADDR_W(ADDR_W), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_read(acc_read),
    .acc_addr(acc_addr), .store_cmd(store_cmd), .recall_cmd(recall_cmd),
    .mem_disable(mem_disable)
  );

  function automatic logic [ADDR_W-1:0] key_at(input int i);
    logic [15:0] k [7] = '{16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0FC0, 16'h0C63};
    return k[i][ADDR_W-1:0];
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // One access cycle with a model prediction and a check of all outputs.
  task automatic cyc(input bit v, input bit rd, input logic [ADDR_W-1:0] ad);
    int hit = 0;
    int nstep = mstep;
    int nbusy;
    acc_valid = v; acc_read = rd; acc_addr = ad;
    if (v && mbusy == 0) begin
      if (!rd) nstep = 0;
      else if (mstep == 5 && ad == key_at(5)) begin hit = 1; nstep = 0; end
      else if (mstep == 5 && ad == key_at(6)) begin hit = 2; nstep = 0; end
      else if (mstep < 5 && ad == key_at(mstep)) nstep = mstep + 1;
      else nstep = (ad == key_at(0)) ? 1 : 0;
    end
    nbusy = (hit == 1) ? SC : (hit == 2) ? RC : ((mbusy > 0) ? mbusy - 1 : 0);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "store_cmd", int'(store_cmd), int'(hit == 1));
    chk(tag, "recall_cmd", int'(recall_cmd), int'(hit == 2));
    chk(tag, "mem_disable", int'(mem_disable), int'(nbusy != 0));
    mstep = nstep;
    mbusy = nbusy;
  endtask

  task automatic prefix();
    for (int i = 0; i < 5; i++) cyc(1, 1, key_at(i));
  endtask

  task automatic drain();
    while (mbusy != 0) cyc(0, 1, '0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "store_cmd in reset", int'(store_cmd), 0);
    chk("R1", "recall_cmd in reset", int'(recall_cmd), 0);
    chk("R1", "mem_disable in reset", int'(mem_disable), 0);
    rst_n = 1'b1;
    cyc(0, 1, '0);

    tag = "R2"; prefix(); cyc(1, 1, key_at(5));
    tag = "R7"; drain();
    tag = "R3"; prefix(); cyc(1, 1, key_at(6));
    tag = "R8"; drain();

    tag = "R4";
    for (int i = 0; i < 3; i++) cyc(1, 1, key_at(i));
    cyc(1, 0, key_at(3));
    for (int i = 3; i < 5; i++) cyc(1, 1, key_at(i));
    cyc(1, 1, key_at(5));
    prefix(); cyc(1, 0, key_at(5));
    chk("R4", "store_cmd after write sixth", int'(store_cmd), 0);

    tag = "R5";
    for (int i = 0; i < 4; i++) cyc(1, 1, key_at(i));
    cyc(1, 1, 15'h1234);
    cyc(1, 1, key_at(4)); cyc(1, 1, key_at(6));
    for (int i = 0; i < 3; i++) cyc(1, 1, key_at(i));
    cyc(1, 1, key_at(0));
    for (int i = 1; i < 5; i++) cyc(1, 1, key_at(i));
    cyc(1, 1, key_at(5));
    chk("R5", "store_cmd after restart at step one", int'(store_cmd), 1);
    drain();

    tag = "R6";
    for (int i = 0; i < 5; i++) begin
      cyc(1, 1, key_at(i));
      cyc(0, 0, 15'h7FFF);
      cyc(0, 1, key_at(0));
    end
    cyc(1, 1, key_at(6));
    chk("R6", "recall_cmd after idle gaps", int'(recall_cmd), 1);

    tag = "R9";
    pulses = 0;
    prefix(); cyc(1, 1, key_at(5));
    pulses += int'(store_cmd) + int'(recall_cmd);
    chk("R9", "no command while disabled", pulses, 0);
    drain();
    cyc(1, 1, key_at(5));
    chk("R9", "lone select after busy", int'(store_cmd), 0);
    prefix(); cyc(1, 1, key_at(5));
    chk("R9", "sequence after busy", int'(store_cmd), 1);
    drain();

    tag = "R10";
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      if (r <= 5) begin
        int k = (mstep < 5) ? mstep : (5 + ($urandom % 2));
        cyc(1, 1, key_at(k));
      end else if (r == 6) cyc(1, 1, key_at(0));
      else if (r == 7) cyc(1, 1, ADDR_W'($urandom));
      else if (r == 8) cyc(1, 0, key_at($urandom % 7));
      else cyc(0, $urandom % 2, ADDR_W'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule